// File: doc/BRIEF.md
# Queue-Port Request Messaging Unit

This block is the controller-side end of a host/controller request channel. The host reaches it through a small register window. Two queue ports carry request handles. A read of the inbound port hands out the offset of a free request slot. A write to the same port posts a request handle for processing. Completed handles wait in an outbound queue until the host reads them from the outbound port. A write to the outbound port gives a controller-memory slot back to the free pool. The host also fills the pool this way after reset.

The local side takes posted handles through a valid/ready pair, and each handle comes with its decoded form. A handle with bit 31 set names a request held in host memory, at a 32-byte-aligned bus address: the address is the low 27 handle bits shifted left by five. Any other handle is a plain offset into controller memory. The local side pushes completed handles into the outbound queue.

An interrupt output goes high while completions are waiting and the mask bit is clear. Sticky bits record any push dropped at a full queue. A pair of message registers carries non-queued commands. The local side completes such a command by echoing its value into the outbound message. A doorbell write sends a one-cycle pulse to the local side.

Top module: `qp_msg_unit`

## Requirements
- R1: After reset all three queues are empty, `irq` is low, `req_valid` is low, and status (0x30) reads 0. A read of 0x40 returns 0xFFFFFFFF, and so does a read of 0x44.
- R2: A read strobe is answered one cycle later: `reg_rvalid` is high and `reg_rdata` holds the data. A read of 0x40 pops the free-slot queue in first-in first-out order. When that queue is empty the read returns 0xFFFFFFFF.
- R3: A write to 0x40 posts `reg_wdata` into the request queue. The local side sees the handles on `req_handle` in posting order. A handle is removed in each cycle where `req_valid` and `req_ready` are both high.
- R4: For a handle with bit 31 set, `req_host` is 1 and `req_addr` is handle[26:0] shifted left by 5. For any other handle, `req_host` is 0 and `req_addr` equals the handle.
- R5: A local push (`cpl_valid`) enqueues `cpl_handle` into the outbound queue. Reads of 0x44 return the completions in order, and return 0xFFFFFFFF when the queue is empty.
- R6: A write to 0x44 pushes `reg_wdata` into the free-slot queue. A later read of 0x40 returns it.
- R7: `irq` is high exactly when the outbound queue is non-empty and bit 0 of the mask register (0x34, read/write) is 0. Status bit 0 shows live whether the outbound queue is non-empty, independent of the mask.
- R8: A push to a full queue (depth 32) is dropped and sets a sticky status bit: bit 1 for the free queue, bit 2 for the request queue, bit 3 for the outbound queue. Writing 1 to a sticky bit at 0x30 clears it. Writing 0 leaves it unchanged.
- R9: A write to 0x10 stores the inbound message. `msg_in` shows the stored value, and `msg_in_stb` pulses for one cycle. `msg_out_we` loads `msg_out_data` into the outbound message, which is readable at 0x18. The inbound message reads back at 0x10.
- R10: A write to 0x20 pulses `db_stb` for one cycle, with `db_bits` carrying the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| req_valid | output | 1 | A posted handle is available |
| req_ready | input | 1 | Local side takes the posted handle |
| req_handle | output | 32 | Posted handle, raw |
| req_host | output | 1 | Handle names a host-memory request |
| req_addr | output | 32 | Decoded byte address or offset |
| cpl_valid | input | 1 | Push a completed handle |
| cpl_handle | input | 32 | Completed handle |
| irq | output | 1 | Outbound interrupt |
| msg_in | output | 32 | Inbound message value |
| msg_in_stb | output | 1 | Inbound message written |
| msg_out_we | input | 1 | Load outbound message |
| msg_out_data | input | 32 | Outbound message value |
| db_stb | output | 1 | Doorbell written |
| db_bits | output | 32 | Doorbell value |

## Verification
The assertions check several properties on every cycle. Every read is answered in the following cycle. An empty-queue read of the inbound port yields all ones. A push into a full queue leaves the occupancy unchanged and sets its sticky bit. The interrupt is never raised while the outbound queue is empty. Doorbell and outbound-message writes land one cycle later. Only the bench scenarios can show first-in first-out ordering across posts, completions and returned slots. They also show the host-address decode of posted handles and that a 33rd push is really lost. The remaining scenario checks cover the write-one-to-clear behaviour together with write-zero immunity, and mask gating of the interrupt as seen through status reads.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int DW = 32;
  localparam logic [7:0] OFS_MSG_IN  = 8'h10;
  localparam logic [7:0] OFS_MSG_OUT = 8'h18;
  localparam logic [7:0] OFS_DBELL   = 8'h20;
  localparam logic [7:0] OFS_STATUS  = 8'h30;
  localparam logic [7:0] OFS_MASK    = 8'h34;
  localparam logic [7:0] OFS_IQ      = 8'h40;
  localparam logic [7:0] OFS_OQ      = 8'h44;
  localparam logic [DW-1:0] EMPTY_WORD = '1;

  typedef struct packed {
    logic          host;
    logic [DW-1:0] addr;
  } handle_dec_t;

  // bit 31 tags host memory; low 27 bits are a 32-byte granule index
  function automatic handle_dec_t decode_handle(input logic [DW-1:0] h);
    handle_dec_t d;
    d.host = h[DW-1];
    d.addr = h[DW-1] ? {h[DW-6:0], 5'b00000} : h;
    return d;
  endfunction
endpackage

// File: rtl/qp_fifo.sv
module qp_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (cnt <= $past(cnt)));
  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/qp_status.sv
module qp_status #(
  parameter int DW     = 32,
  parameter int NDROP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NDROP-1:0] drop_ev,
  input  logic             oq_pending,
  input  logic             stat_we,
  input  logic             mask_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    status,
  output logic [DW-1:0]    mask,
  output logic             irq
);
  logic [NDROP-1:0] sticky;

  for (genvar i = 0; i < NDROP; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rst_n)          sticky[i] <= 1'b0;
      else if (drop_ev[i]) sticky[i] <= 1'b1;
      else if (stat_we && wdata[i+1]) sticky[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= wdata;
  end

  assign status = {{(DW-NDROP-1){1'b0}}, sticky, oq_pending};
  assign irq    = oq_pending && !mask[0];

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev[0] |=> status[1]);
endmodule

// File: rtl/qp_msg_unit.sv
module qp_msg_unit #(
  parameter int ADDR_W = 8,
  parameter int DW     = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DW-1:0]     req_handle,
  output logic              req_host,
  output logic [DW-1:0]     req_addr,
  input  logic              cpl_valid,
  input  logic [DW-1:0]     cpl_handle,
  output logic              irq,
  output logic [DW-1:0]     msg_in,
  output logic              msg_in_stb,
  input  logic              msg_out_we,
  input  logic [DW-1:0]     msg_out_data,
  output logic              db_stb,
  output logic [DW-1:0]     db_bits
);
  import qp_pkg::*;

  logic hit_iq, hit_oq;
  logic wr_iq, wr_oq, rd_iq, rd_oq, wr_msg, wr_db, wr_stat, wr_mask;
  assign hit_iq  = (reg_addr == ADDR_W'(OFS_IQ));
  assign hit_oq  = (reg_addr == ADDR_W'(OFS_OQ));
  assign wr_iq   = reg_wr && hit_iq;
  assign wr_oq   = reg_wr && hit_oq;
  assign rd_iq   = reg_rd && hit_iq;
  assign rd_oq   = reg_rd && hit_oq;
  assign wr_msg  = reg_wr && (reg_addr == ADDR_W'(OFS_MSG_IN));
  assign wr_db   = reg_wr && (reg_addr == ADDR_W'(OFS_DBELL));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
  assign wr_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));

  logic [DW-1:0] free_dout, post_dout, cpl_dout;
  logic free_empty, post_empty, cpl_empty;
  logic free_full, post_full, cpl_full;
  logic free_drop, post_drop, cpl_drop;

  qp_fifo #(.DEPTH(DEPTH), .W(DW)) u_free (
    .clk(clk), .rst_n(rst_n), .push(wr_oq), .din(reg_wdata), .pop(rd_iq),
    .dout(free_dout), .empty(free_empty), .full(free_full), .drop(free_drop));

  qp_fifo #(.DEPTH(DEPTH), .W(DW)) u_post (
    .clk(clk), .rst_n(rst_n), .push(wr_iq), .din(reg_wdata),
    .pop(req_valid && req_ready),
    .dout(post_dout), .empty(post_empty), .full(post_full), .drop(post_drop));

  qp_fifo #(.DEPTH(DEPTH), .W(DW)) u_cpl (
    .clk(clk), .rst_n(rst_n), .push(cpl_valid), .din(cpl_handle), .pop(rd_oq),
    .dout(cpl_dout), .empty(cpl_empty), .full(cpl_full), .drop(cpl_drop));

  logic [DW-1:0] status, mask;
  qp_status #(.DW(DW), .NDROP(3)) u_status (
    .clk(clk), .rst_n(rst_n), .drop_ev({cpl_drop, post_drop, free_drop}),
    .oq_pending(!cpl_empty), .stat_we(wr_stat), .mask_we(wr_mask),
    .wdata(reg_wdata), .status(status), .mask(mask), .irq(irq));

  handle_dec_t dec;
  assign dec        = decode_handle(post_dout);
  assign req_valid  = !post_empty;
  assign req_handle = post_dout;
  assign req_host   = dec.host;
  assign req_addr   = dec.addr;

  logic [DW-1:0] msg_out_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_in     <= '0;
      msg_in_stb <= 1'b0;
      msg_out_q  <= '0;
      db_stb     <= 1'b0;
      db_bits    <= '0;
    end else begin
      msg_in_stb <= wr_msg;
      if (wr_msg)     msg_in    <= reg_wdata;
      if (msg_out_we) msg_out_q <= msg_out_data;
      db_stb <= wr_db;
      if (wr_db) db_bits <= reg_wdata;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_iq)      rd_mux = free_empty ? EMPTY_WORD : free_dout;
    else if (hit_oq) rd_mux = cpl_empty ? EMPTY_WORD : cpl_dout;
    else if (reg_addr == ADDR_W'(OFS_MSG_IN))  rd_mux = msg_in;
    else if (reg_addr == ADDR_W'(OFS_MSG_OUT)) rd_mux = msg_out_q;
    else if (reg_addr == ADDR_W'(OFS_STATUS))  rd_mux = status;
    else if (reg_addr == ADDR_W'(OFS_MASK))    rd_mux = mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R2
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  // R1
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iq && free_empty) |=> (reg_rdata == EMPTY_WORD));
  // R7
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !cpl_empty);
  // R10
  db_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_db |=> (db_stb && db_bits == $past(reg_wdata)));
  // R9
  msg_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_we |=> (msg_out_q == $past(msg_out_data)));
endmodule

// File: tb/qp_msg_unit_bench.sv
module qp_msg_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic req_valid, req_ready = 0, req_host;
  logic [31:0] req_handle, req_addr;
  logic cpl_valid = 0;
  logic [31:0] cpl_handle = '0;
  logic irq, msg_in_stb, db_stb;
  logic [31:0] msg_in, db_bits;
  logic msg_out_we = 0;
  logic [31:0] msg_out_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  qp_msg_unit u_qp_msg_unit (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    check("R2 rvalid", {31'b0, reg_rvalid}, 1);
    d = reg_rdata;
  endtask

  function automatic logic [31:0] host_addr(input logic [31:0] h);
    return (h & 32'h07FF_FFFF) * 32;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 req_valid", {31'b0, req_valid}, 0);
    rd(8'h40, d); check("R1 iq empty", d, 32'hFFFF_FFFF);
    rd(8'h44, d); check("R1 oq empty", d, 32'hFFFF_FFFF);
    rd(8'h30, d); check("R1 status", d, 0);
  endtask

  task automatic t_msg_db();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0055);
    check("R9 stb", {31'b0, msg_in_stb}, 1);
    check("R9 msg_in", msg_in, 32'h55);
    @(negedge clk); check("R9 stb pulse", {31'b0, msg_in_stb}, 0);
    rd(8'h10, d); check("R9 read in", d, 32'h55);
    @(negedge clk); msg_out_we = 1; msg_out_data = 32'h55;
    @(negedge clk); msg_out_we = 0;
    rd(8'h18, d); check("R9 echo", d, 32'h55);
    wr(8'h20, 32'h0000_0004);
    check("R10 db_stb", {31'b0, db_stb}, 1);
    check("R10 db_bits", db_bits, 32'h4);
    @(negedge clk); check("R10 pulse", {31'b0, db_stb}, 0);
  endtask

  task automatic t_post();
    logic [31:0] h1, h2;
    h1 = 32'h0000_1200; h2 = 32'h8000_0010;
    wr(8'h40, h1); wr(8'h40, h2);
    check("R3 valid", {31'b0, req_valid}, 1);
    check("R3 first", req_handle, h1);
    check("R4 ctl host", {31'b0, req_host}, 0);
    check("R4 ctl addr", req_addr, h1);
    req_ready = 1; @(negedge clk); req_ready = 0;
    check("R3 second", req_handle, h2);
    check("R4 host flag", {31'b0, req_host}, 1);
    check("R4 host addr", req_addr, host_addr(h2));
    req_ready = 1; @(negedge clk); req_ready = 0;
    check("R3 drained", {31'b0, req_valid}, 0);
  endtask

  task automatic t_cpl();
    logic [31:0] d;
    @(negedge clk); cpl_valid = 1; cpl_handle = 32'hA;
    @(negedge clk); cpl_handle = 32'hB;
    @(negedge clk); cpl_valid = 0;
    check("R7 irq on", {31'b0, irq}, 1);
    rd(8'h30, d); check("R7 status pending", d, 1);
    wr(8'h34, 1);
    check("R7 masked", {31'b0, irq}, 0);
    rd(8'h34, d); check("R7 mask read", d, 1);
    rd(8'h30, d); check("R7 status live under mask", d, 1);
    wr(8'h34, 0);
    check("R7 unmasked", {31'b0, irq}, 1);
    rd(8'h44, d); check("R5 first", d, 32'hA);
    rd(8'h44, d); check("R5 second", d, 32'hB);
    rd(8'h44, d); check("R5 empty", d, 32'hFFFF_FFFF);
    check("R7 irq off", {31'b0, irq}, 0);
  endtask

  task automatic t_free_overflow();
    logic [31:0] d;
    wr(8'h44, 32'h300); rd(8'h40, d); check("R6 returned slot", d, 32'h300);
    for (int i = 0; i < 33; i++) wr(8'h44, 32'h100 + i * 32'h40);
    rd(8'h30, d); check("R8 sticky set", d, 32'h2);
    wr(8'h30, 32'h0);
    rd(8'h30, d); check("R8 write zero keeps", d, 32'h2);
    wr(8'h30, 32'h2);
    rd(8'h30, d); check("R8 w1c", d, 32'h0);
    for (int i = 0; i < 32; i++) begin
      rd(8'h40, d); check("R2 fifo order", d, 32'h100 + i * 32'h40);
    end
    rd(8'h40, d); check("R8 33rd dropped", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_msg_db();
    t_post();
    t_cpl();
    t_free_overflow();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule